// File: doc/BRIEF.md
# Section CRC-32 residue checker

This block verifies a data section whose final four bytes hold a 32-bit CRC. Bytes arrive one per accepted cycle on an 8-bit bus with a valid strobe. A start pulse opens a section and reloads the checksum register with all ones. A last flag marks the final CRC byte. Every byte, the CRC bytes included, is folded into a 32-bit shift register. The bits go in most significant bit first and nothing is reflected. The generator is x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. A correctly encoded section leaves the register at zero. No final inversion is applied and no magic constant is compared.

A byte-parallel step unrolls eight serial shifts, so one byte is absorbed per clock. A two-state controller tracks whether a section is open.
- **ST_IDLE**: no section is open.
- **ST_ACTIVE**: a section is being absorbed.

The transitions are:
- **T_OPEN** (ST_IDLE to ST_ACTIVE): start without a same-cycle last byte.
- **T_CLOSE** (ST_ACTIVE to ST_IDLE): a last byte is accepted.
- **T_REOPEN** (ST_ACTIVE to ST_ACTIVE): start arrives in the middle of a section.
- **T_SINGLE** (stays in ST_IDLE): start and a last byte arrive in one cycle.

A one-cycle done pulse and a held pass flag follow each closing byte. The register value is visible at all times.

Top module: `section_crc_checker`

## Requirements
- R1: The register update matches the listed generator. A bit b is absorbed as fb = b XOR z31. The register then shifts up by one, and the constant 0x04C11DB7 is XORed in when fb is 1. The ASCII string "123456789" leaves residue 0x0376E6E7.
- R2: A start pulse with in_valid low loads residue with 0xFFFFFFFF on the next clock.
- R3: Each byte is absorbed in the order bit 7 down to bit 0. For example, 0x01 feeds seven zeros and then a one.
- R4: The four trailing CRC bytes also pass through the register. When they are sent most significant byte first, a correctly encoded section leaves residue 0 and crc_ok 1.
- R5: In cycles with in_valid low and start low, residue is unchanged. Idle gaps inside a section do not alter the result.
- R6: At each done pulse, crc_ok is 1 exactly when residue is zero. Flipping any single bit of a section, including a bit in the CRC field, gives crc_ok 0.
- R7: done is high for the single cycle after an accepted byte with in_last. It is low otherwise. crc_ok holds its value between done pulses.
- R8: A byte offered with in_valid high while no section is open and start is low is ignored. residue and done do not change.
- R9: When start and in_valid coincide, that byte is absorbed against the all-ones value. A new section may start in the cycle right after the previous last byte.
- R10: A start pulse in the middle of a section discards the partial result and begins a new section.
- R11: After reset, residue is 0xFFFFFFFF, done is 0 and crc_ok is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a section and reloads the register with all ones |
| in_valid | input | 1 | in_byte holds a byte this cycle |
| in_byte | input | 8 | Section byte, most significant bit absorbed first |
| in_last | input | 1 | Marks the final CRC byte of the section |
| done | output | 1 | One-cycle pulse after the closing byte |
| crc_ok | output | 1 | Pass flag, updated at done |
| residue | output | 32 | Current register contents |

## Verification
The hardest case to reach is a start that lands on the same cycle as a data byte. It is especially hard when that cycle directly follows the previous section's closing byte. There, the reload, the absorption and the done pulse of the old section all interact. The bench drives two sections as one gapless byte stream, with start on the first byte of each. It checks the first section's verdict on the same negative edge at which the second section's opening byte is driven. Single-bit flips are placed in both the payload and the CRC field, so that corruption anywhere in a section is caught.

// File: rtl/section_crc_pkg.sv
package section_crc_pkg;
    localparam int CRC_W  = 32;
    localparam int DATA_W = 8;
    localparam logic [CRC_W-1:0] GEN_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] SEED     = {CRC_W{1'b1}};

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } sec_state_e;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
    parameter int CRC_W = 32,
    parameter int DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    // chain[k] is the register after k serial shifts
    logic [CRC_W-1:0] chain [0:DATA_W];

    assign chain[0] = crc_in;

    genvar k;
    generate
        for (k = 0; k < DATA_W; k++) begin : g_bit
            logic fb;
            assign fb = data_in[DATA_W-1-k] ^ chain[k][CRC_W-1];
            assign chain[k+1] = {chain[k][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/crc_section_fsm.sv
module crc_section_fsm
    import section_crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       accept,
    output logic       finish,
    output logic       done,
    output sec_state_e state
);
    sec_state_e state_d;

    assign accept = in_valid && (start || state == ST_ACTIVE);
    assign finish = accept && in_last;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (start && !finish) state_d = ST_ACTIVE;   // T_OPEN
            end
            ST_ACTIVE: begin
                if (finish) state_d = ST_IDLE;               // T_CLOSE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= finish;
    end

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        finish |=> done);
    p_done_only_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        !finish |=> !done);
    p_no_accept_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |-> !accept);
endmodule

// File: rtl/crc_residue_reg.sv
module crc_residue_reg #(
    parameter int CRC_W = 32,
    parameter logic [CRC_W-1:0] SEED = {CRC_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             accept,
    input  logic             finish,
    input  logic [CRC_W-1:0] next_crc,
    output logic [CRC_W-1:0] crc_q,
    output logic             ok_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= SEED;
            ok_q  <= 1'b0;
        end else begin
            if (accept)       crc_q <= next_crc;
            else if (restart) crc_q <= SEED;
            if (finish)       ok_q  <= (next_crc == '0);
        end
    end

    p_init_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        (restart && !accept) |=> crc_q == SEED);
    p_hold_when_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!accept && !restart) |=> $stable(crc_q));
    p_ok_held_r7: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(ok_q));
endmodule

// File: rtl/section_crc_checker.sv
module section_crc_checker
    import section_crc_pkg::*;
#(
    parameter int CRC_W = section_crc_pkg::CRC_W,
    parameter int DATA_W = section_crc_pkg::DATA_W,
    parameter logic [CRC_W-1:0] POLY = section_crc_pkg::GEN_POLY,
    parameter logic [CRC_W-1:0] INIT = section_crc_pkg::SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_last,
    output logic              done,
    output logic              crc_ok,
    output logic [CRC_W-1:0]  residue
);
    logic             accept;
    logic             finish;
    sec_state_e       state;
    logic [CRC_W-1:0] base_crc;
    logic [CRC_W-1:0] next_crc;

    crc_section_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .in_last  (in_last),
        .accept   (accept),
        .finish   (finish),
        .done     (done),
        .state    (state)
    );

    // a byte that arrives with start is folded against the seed
    assign base_crc = start ? INIT : residue;

    crc_byte_step #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_step (
        .crc_in  (base_crc),
        .data_in (in_byte),
        .crc_out (next_crc)
    );

    crc_residue_reg #(
        .CRC_W (CRC_W),
        .SEED  (INIT)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .restart  (start),
        .accept   (accept),
        .finish   (finish),
        .next_crc (next_crc),
        .crc_q    (residue),
        .ok_q     (crc_ok)
    );

    p_ok_matches_zero_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (crc_ok == (residue == '0)));
    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> $stable(residue));
endmodule

// File: tb/section_crc_checker_test.sv
`timescale 1ns/1ps
module section_crc_checker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_last = 1'b0;
    logic        done;
    logic        crc_ok;
    logic [31:0] residue;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    logic [7:0] msg [0:31];

    always #2.5 clk = ~clk;

    section_crc_checker uut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_byte(in_byte), .in_last(in_last),
        .done(done), .crc_ok(crc_ok), .residue(residue)
    );

    // {len[3:0], data[63:0] msb byte first, flip index (FF = none)}
    localparam logic [75:0] VEC [7] = '{
        {4'd4, 64'hDEAD_BEEF_0000_0000, 8'hFF},
        {4'd8, 64'h0123_4567_89AB_CDEF, 8'hFF},
        {4'd8, 64'h0123_4567_89AB_CDEF, 8'd0},
        {4'd8, 64'h0123_4567_89AB_CDEF, 8'd95},
        {4'd3, 64'hA55A_C300_0000_0000, 8'd40},
        {4'd1, 64'h8000_0000_0000_0000, 8'd7},
        {4'd6, 64'h0000_0000_0000_0000, 8'hFF}
    };

    task automatic check(input bit cond, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference: bit-serial, msb first, seed all ones, over msg[0..n-1]
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic top = c[31] ^ msg[i][b];
                c = c << 1;
                if (top) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    task automatic append_crc(input int n);
        logic [31:0] c = ref_crc(n);
        msg[n]   = c[31:24];
        msg[n+1] = c[23:16];
        msg[n+2] = c[15:8];
        msg[n+3] = c[7:0];
    endtask

    // drives msg[0..n-1] as one section; gap inserts an idle cycle after each byte
    task automatic send(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = (i == 0);
            in_valid = 1'b1;
            in_byte = msg[i];
            in_last = (i == n - 1);
            if (gap && i != n - 1) begin
                @(negedge clk);
                start = 1'b0;
                in_valid = 1'b0;
                in_byte = 8'h5A;
                in_last = 1'b0;
            end
        end
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(residue == 32'hFFFF_FFFF, "R11 residue", residue, 32'hFFFF_FFFF);
        check(done == 1'b0, "R11 done", {31'd0, done}, 32'd0);
        check(crc_ok == 1'b0, "R11 crc_ok", {31'd0, crc_ok}, 32'd0);

        // table walk: R4, R6
        for (int v = 0; v < 7; v++) begin
            int n = int'(VEC[v][75:72]);
            int fl = int'(VEC[v][7:0]);
            for (int i = 0; i < n; i++) msg[i] = VEC[v][71 - 8*i -: 8];
            append_crc(n);
            if (fl != 255) msg[fl / 8] = msg[fl / 8] ^ (8'h80 >> (fl % 8));
            exp = ref_crc(n + 4);
            send(n + 4, 1'b0);
            check(done == 1'b1, "R7 done at end", {31'd0, done}, 32'd1);
            check(residue == exp, "R4 residue", residue, exp);
            check(crc_ok == (fl == 255), "R6 crc_ok verdict",
                  {31'd0, crc_ok}, {31'd0, fl == 255});
            if (fl != 255) check(residue != 32'd0, "R6 flip nonzero", residue, 32'd1);
        end

        // R1 standard check string, no CRC appended
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        send(9, 1'b0);
        check(residue == 32'h0376_E6E7, "R1 check value", residue, 32'h0376_E6E7);
        check(crc_ok == 1'b0, "R6 bad verdict", {31'd0, crc_ok}, 32'd0);
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", {31'd0, done}, 32'd0);

        // R3 bit order: 0x01 and 0x80 differ, each matches msb-first reference
        msg[0] = 8'h01;
        exp = ref_crc(1);
        send(1, 1'b0);
        check(residue == exp, "R3 byte 0x01", residue, exp);
        msg[0] = 8'h80;
        exp = ref_crc(1);
        send(1, 1'b0);
        check(residue == exp, "R3 byte 0x80", residue, exp);

        // R2 start alone reloads all ones
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(residue == 32'hFFFF_FFFF, "R2 start reload", residue, 32'hFFFF_FFFF);
        // close that open section with a good one to get back to idle
        for (int i = 0; i < 5; i++) msg[i] = 8'h10 * 8'(i);
        append_crc(5);
        send(9, 1'b0);
        check(crc_ok == 1'b1, "R4 after reload", {31'd0, crc_ok}, 32'd1);

        // R5 gaps inside a section
        for (int i = 0; i < 7; i++) msg[i] = 8'hC0 + 8'(i);
        append_crc(7);
        send(11, 1'b1);
        check(residue == 32'd0, "R5 gapped residue", residue, 32'd0);
        check(crc_ok == 1'b1, "R5 gapped ok", {31'd0, crc_ok}, 32'd1);
        repeat (3) @(negedge clk);
        check(crc_ok == 1'b1, "R7 crc_ok held", {31'd0, crc_ok}, 32'd1);
        check(residue == 32'd0, "R5 idle hold", residue, 32'd0);

        // R8 bytes outside a section ignored
        held = residue;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte = 8'hE7;
            in_last = (i == 2);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        check(residue == held, "R8 residue unchanged", residue, held);
        check(done == 1'b0, "R8 no done", {31'd0, done}, 32'd0);

        // R10 restart mid-section
        msg[0] = 8'h11; msg[1] = 8'h22; msg[2] = 8'h33;
        send(2, 1'b0);
        @(negedge clk);
        start = 1'b1; in_valid = 1'b1; in_byte = 8'h99; in_last = 1'b0;
        @(negedge clk);
        start = 1'b0; in_byte = 8'h77;
        for (int i = 0; i < 4; i++) msg[i] = 8'h3C ^ 8'(i);
        append_crc(4);
        send(8, 1'b0);
        check(residue == 32'd0, "R10 restart residue", residue, 32'd0);
        check(crc_ok == 1'b1, "R10 restart ok", {31'd0, crc_ok}, 32'd1);

        // R9 back-to-back sections, no idle cycle; second one corrupted
        for (int i = 0; i < 4; i++) msg[i] = 8'hA0 + 8'(i);
        append_crc(4);
        for (int i = 0; i < 3; i++) msg[8 + i] = 8'h0F << i;
        begin
            logic [7:0] a [0:7];
            for (int i = 0; i < 8; i++) a[i] = msg[i];
            for (int i = 0; i < 3; i++) msg[i] = msg[8 + i];
            append_crc(3);
            msg[5] = msg[5] ^ 8'h04;
            exp = ref_crc(7);
            for (int i = 0; i < 7; i++) msg[8 + i] = msg[i];
            for (int i = 0; i < 8; i++) msg[i] = a[i];
        end
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (i == 8) begin
                check(done == 1'b1, "R9 first done", {31'd0, done}, 32'd1);
                check(crc_ok == 1'b1, "R9 first ok", {31'd0, crc_ok}, 32'd1);
            end
            start = (i == 0 || i == 8);
            in_valid = 1'b1;
            in_byte = msg[i];
            in_last = (i == 7 || i == 14);
        end
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        check(done == 1'b1, "R9 second done", {31'd0, done}, 32'd1);
        check(residue == exp, "R9 second residue", residue, exp);
        check(crc_ok == 1'b0, "R9 second bad", {31'd0, crc_ok}, 32'd0);

        // R11 reset mid-section
        msg[0] = 8'h42;
        @(negedge clk);
        start = 1'b1; in_valid = 1'b1; in_byte = 8'h42;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(residue == 32'hFFFF_FFFF, "R11 reset residue", residue, 32'hFFFF_FFFF);
        check(crc_ok == 1'b0, "R11 reset ok", {31'd0, crc_ok}, 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule